// File: doc/BRIEF.md
# Eight-Port Shuffle-Exchange Packet Router

This block moves packets between eight sources and eight destinations through three ranks of 2x2 switching elements. Every source port and every destination port carries a 3-bit label equal to its index. A packet enters with a destination label and a payload, and the block attaches the source label on entry. Before each rank, the lane index is rotated left by one bit (a perfect shuffle). Each element then decides on its own whether a packet goes straight or crosses. It makes that choice by comparing one bit of the source label with the same bit of the destination label, starting at the most significant bit in the first rank and moving one bit lower in each later rank. No central decode of the whole connection pattern is needed.

Each rank is registered, so a packet that meets no contention takes three cycles to cross the block. Every input and every output uses a valid/ready handshake, and stalls propagate back through the ranks. Sometimes both inputs of one element need the same output in the same cycle. The packet on the lower-numbered lane of that element then moves on, and the other packet waits with its ready signal held low.

Top module: `omega_net`

## Requirements
- R1: In the first cycle after synchronous reset is released, all `out_valid` bits are 0 and all `in_ready` bits are 1.
- R2: A packet accepted at input `s` with destination `d` is presented at output `d` with `out_src` = `s`, `out_dst` = `d` and its payload unchanged. A valid output never carries a destination label different from its own port index.
- R3: With no contention and every `out_ready` high, a packet accepted in cycle c is shown on its output in cycle c+3 and not before.
- R4: Before each rank the lane index `i` is rotated left by one bit. Rank k (k = 0, 1, 2) pairs lanes 2j and 2j+1 into element j. An element forwards a packet to the same-parity output (straight) when source bit 2-k equals destination bit 2-k, and to the other output (cross) when they differ. In the first rank this makes sources `j` and `j+4` the two inputs of element j.
- R5: When both inputs of an element need the same output in one cycle, the lower-numbered lane wins. In the first rank this means source `j` (j < 4) is accepted while `in_ready[j+4]` is 0, and the loser is accepted one cycle later.
- R6: Two packets that share a first-rank element but have different destination MSBs are both accepted in the same cycle and are delivered in the same cycle.
- R7: The identity permutation (d = s) and the complement permutation (d = s XOR 7) are conflict-free. All eight packets are accepted in one cycle and all eight outputs go valid together three cycles later.
- R8: A stream from one source to one destination, with that output ready, is accepted every cycle and delivered one packet per cycle in order.
- R9: While `out_valid[d]` is 1 and `out_ready[d]` is 0, output `d` stays valid with stable source, destination and payload. After release, the queued packets leave in acceptance order on consecutive cycles.
- R10: With `out_ready[d]` held low, a source streaming to `d` gets exactly three packets accepted (one per rank), and its `in_ready` drops on the fourth. It rises again in the cycle `out_ready[d]` returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 8 | Per-source packet valid |
| in_ready | output | 8 | Per-source accept; a packet moves when valid and ready are both 1 |
| in_dst | input | 24 | Destination label per source, 3 bits each, source s at bits [3s+2:3s] |
| in_data | input | 64 | Payload per source, 8 bits each, source s at bits [8s+7:8s] |
| out_valid | output | 8 | Per-destination packet valid |
| out_ready | input | 8 | Per-destination accept from the consumer |
| out_src | output | 24 | Source label of the packet at each output, 3 bits each |
| out_dst | output | 24 | Destination label of the packet at each output, 3 bits each |
| out_data | output | 64 | Payload at each output, 8 bits each |

## Verification
Single packets over several source/destination pairs confirm that the straight/cross decisions add up to the right output and that exactly three register ranks lie on the path. A pair that collides in a first-rank element is compared with a pair that shares the element but splits on the destination MSB. This separates the priority rule from false blocking. The identity and complement permutations show that conflict-free patterns move at full width. A single-source stream, run once with its output open and once with it blocked, shows the one-per-cycle rate, ordering, hold stability and the three-deep stall capacity.

// File: rtl/omega_pkg.sv
package omega_pkg;

    localparam int LBL_W = 3;
    localparam int PORTS = 1 << LBL_W;
    localparam int ELEMS = PORTS / 2;
    localparam int PAY_W = 8;

    typedef logic [LBL_W-1:0] label_t;
    typedef logic [PAY_W-1:0] pay_t;

    typedef struct packed {
        logic   vld;
        label_t src;
        label_t dst;
        pay_t   pay;
    } flit_t;

    // perfect shuffle: rotate lane index left by one bit
    function automatic label_t shuffle(label_t idx);
        return {idx[LBL_W-2:0], idx[LBL_W-1]};
    endfunction

    // straight keeps the lane side, cross flips it
    function automatic logic pick_port(logic side, logic s_bit, logic d_bit);
        return side ^ (s_bit ^ d_bit);
    endfunction

endpackage

// File: rtl/omega_shuffle.sv
module omega_shuffle
    import omega_pkg::*;
(
    input  flit_t [PORTS-1:0] din,
    output logic  [PORTS-1:0] din_rdy,
    output flit_t [PORTS-1:0] dout,
    input  logic  [PORTS-1:0] dout_rdy
);

    always_comb begin
        dout    = '0;
        din_rdy = '0;
        for (int i = 0; i < PORTS; i++) begin
            dout[shuffle(label_t'(i))] = din[i];
            din_rdy[i] = dout_rdy[shuffle(label_t'(i))];
        end
    end

endmodule

// File: rtl/omega_elem.sv
module omega_elem
    import omega_pkg::*;
#(
    parameter int BITPOS = LBL_W - 1
) (
    input  logic  clk,
    input  logic  rst,
    input  flit_t up_in,
    input  flit_t lo_in,
    output logic  up_rdy,
    output logic  lo_rdy,
    output flit_t out0,
    output flit_t out1,
    input  logic  out0_rdy,
    input  logic  out1_rdy
);

    logic        up_port;
    logic        lo_port;
    logic [1:0]  can_load;
    logic [1:0]  up_take;
    logic [1:0]  lo_take;
    flit_t [1:0] held_q;

    always_comb begin
        up_port     = pick_port(1'b0, up_in.src[BITPOS], up_in.dst[BITPOS]);
        lo_port     = pick_port(1'b1, lo_in.src[BITPOS], lo_in.dst[BITPOS]);
        can_load[0] = !held_q[0].vld || out0_rdy;
        can_load[1] = !held_q[1].vld || out1_rdy;
        for (int p = 0; p < 2; p++) begin
            up_take[p] = up_in.vld && (up_port == p[0]) && can_load[p];
            lo_take[p] = lo_in.vld && (lo_port == p[0]) && can_load[p]
                         && !(up_in.vld && (up_port == p[0]));
        end
        up_rdy = can_load[up_port];
        lo_rdy = can_load[lo_port] && !(up_in.vld && (up_port == lo_port));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= '0;
        end else begin
            for (int p = 0; p < 2; p++) begin
                if (can_load[p]) begin
                    if (up_take[p])      held_q[p] <= up_in;
                    else if (lo_take[p]) held_q[p] <= lo_in;
                    else                 held_q[p] <= '0;
                end
            end
        end
    end

    assign out0 = held_q[0];
    assign out1 = held_q[1];

endmodule

// File: rtl/omega_stage.sv
module omega_stage
    import omega_pkg::*;
#(
    parameter int BITPOS = LBL_W - 1
) (
    input  logic              clk,
    input  logic              rst,
    input  flit_t [PORTS-1:0] din,
    output logic  [PORTS-1:0] din_rdy,
    output flit_t [PORTS-1:0] dout,
    input  logic  [PORTS-1:0] dout_rdy
);

    for (genvar j = 0; j < ELEMS; j++) begin : g_elem
        omega_elem #(.BITPOS(BITPOS)) u_elem (
            .clk      (clk),
            .rst      (rst),
            .up_in    (din[2*j]),
            .lo_in    (din[2*j+1]),
            .up_rdy   (din_rdy[2*j]),
            .lo_rdy   (din_rdy[2*j+1]),
            .out0     (dout[2*j]),
            .out1     (dout[2*j+1]),
            .out0_rdy (dout_rdy[2*j]),
            .out1_rdy (dout_rdy[2*j+1])
        );
    end

endmodule

// File: rtl/omega_net.sv
module omega_net
    import omega_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic [PORTS-1:0]       in_valid,
    output logic [PORTS-1:0]       in_ready,
    input  logic [PORTS*LBL_W-1:0] in_dst,
    input  logic [PORTS*PAY_W-1:0] in_data,
    output logic [PORTS-1:0]       out_valid,
    input  logic [PORTS-1:0]       out_ready,
    output logic [PORTS*LBL_W-1:0] out_src,
    output logic [PORTS*LBL_W-1:0] out_dst,
    output logic [PORTS*PAY_W-1:0] out_data
);

    flit_t [PORTS-1:0] entry;
    flit_t [PORTS-1:0] lane     [LBL_W+1];
    logic  [PORTS-1:0] lane_rdy [LBL_W+1];
    flit_t [PORTS-1:0] mixd     [LBL_W];
    logic  [PORTS-1:0] mixd_rdy [LBL_W];

    always_comb begin
        for (int i = 0; i < PORTS; i++) begin
            entry[i].vld = in_valid[i];
            entry[i].src = label_t'(i);
            entry[i].dst = in_dst[i*LBL_W +: LBL_W];
            entry[i].pay = in_data[i*PAY_W +: PAY_W];
        end
    end

    assign lane[0]         = entry;
    assign lane_rdy[LBL_W] = out_ready;
    assign in_ready        = lane_rdy[0];

    for (genvar k = 0; k < LBL_W; k++) begin : g_rank
        omega_shuffle u_mix (
            .din      (lane[k]),
            .din_rdy  (lane_rdy[k]),
            .dout     (mixd[k]),
            .dout_rdy (mixd_rdy[k])
        );
        omega_stage #(.BITPOS(LBL_W - 1 - k)) u_stage (
            .clk      (clk),
            .rst      (rst),
            .din      (mixd[k]),
            .din_rdy  (mixd_rdy[k]),
            .dout     (lane[k+1]),
            .dout_rdy (lane_rdy[k+1])
        );
    end

    always_comb begin
        for (int i = 0; i < PORTS; i++) begin
            out_valid[i]                 = lane[LBL_W][i].vld;
            out_src[i*LBL_W +: LBL_W]    = lane[LBL_W][i].src;
            out_dst[i*LBL_W +: LBL_W]    = lane[LBL_W][i].dst;
            out_data[i*PAY_W +: PAY_W]   = lane[LBL_W][i].pay;
        end
    end

endmodule

// File: rtl/omega_chk.sv
module omega_chk
    import omega_pkg::*;
(
    input logic                   clk,
    input logic                   rst,
    input logic [PORTS-1:0]       in_valid,
    input logic [PORTS-1:0]       in_ready,
    input logic [PORTS*LBL_W-1:0] in_dst,
    input logic [PORTS-1:0]       out_valid,
    input logic [PORTS-1:0]       out_ready,
    input logic [PORTS*LBL_W-1:0] out_src,
    input logic [PORTS*LBL_W-1:0] out_dst,
    input logic [PORTS*PAY_W-1:0] out_data
);

    assert_reset_empty_R1: assert property (@(posedge clk)
        $fell(rst) |-> (out_valid == '0));

    for (genvar i = 0; i < PORTS; i++) begin : g_out
        assert_dst_match_R2: assert property (@(posedge clk) disable iff (rst)
            out_valid[i] |-> (out_dst[i*LBL_W +: LBL_W] == LBL_W'(i)));

        assert_hold_valid_R9: assert property (@(posedge clk) disable iff (rst)
            (out_valid[i] && !out_ready[i]) |=> out_valid[i]);

        assert_hold_stable_R9: assert property (@(posedge clk) disable iff (rst)
            (out_valid[i] && !out_ready[i]) |=>
                ($stable(out_data[i*PAY_W +: PAY_W]) && $stable(out_src[i*LBL_W +: LBL_W])));
    end

    for (genvar j = 0; j < ELEMS; j++) begin : g_pri
        assert_low_lane_wins_R5: assert property (@(posedge clk) disable iff (rst)
            (in_valid[j] && in_valid[j+ELEMS] &&
             (in_dst[j*LBL_W + LBL_W-1] == in_dst[(j+ELEMS)*LBL_W + LBL_W-1]))
            |-> !in_ready[j+ELEMS]);
    end

endmodule

bind omega_net omega_chk u_chk (.*);

// File: tb/sim_omega_net.sv
module sim_omega_net;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  in_valid = '0;
    logic [7:0]  in_ready;
    logic [23:0] in_dst = '0;
    logic [63:0] in_data = '0;
    logic [7:0]  out_valid;
    logic [7:0]  out_ready = 8'hFF;
    logic [23:0] out_src;
    logic [23:0] out_dst;
    logic [63:0] out_data;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_P/2) clk = ~clk;

    omega_net u0 (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_dst(in_dst), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_src(out_src), .out_dst(out_dst), .out_data(out_data)
    );

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic put(int s, int d, int pay);
        in_valid[s]        = 1'b1;
        in_dst[s*3 +: 3]   = 3'(d);
        in_data[s*8 +: 8]  = 8'(pay);
    endtask

    function automatic int o_src(int p); return int'(out_src[p*3 +: 3]); endfunction
    function automatic int o_dst(int p); return int'(out_dst[p*3 +: 3]); endfunction
    function automatic int o_dat(int p); return int'(out_data[p*8 +: 8]); endfunction

    task automatic chk_out(string req, int p, int s, int pay);
        chk(req, "out_src", o_src(p), s);
        chk("R2", "out_dst equals port", o_dst(p), p);
        chk(req, "out_data", o_dat(p), pay);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) step();
        rst = 1'b0;
        step();
        #1;
        chk("R1", "out_valid after reset", int'(out_valid), 0);
        chk("R1", "in_ready after reset", int'(in_ready), 8'hFF);
    endtask

    task automatic t_single(int s, int d, int pay);
        step();
        put(s, d, pay);
        #1;
        chk("R2", "in_ready single", int'(in_ready[s]), 1);
        step();
        in_valid = '0;
        step();
        #1;
        chk("R3", "out_valid two cycles after accept", int'(out_valid), 0);
        step();
        #1;
        chk("R3", "out_valid three cycles after accept", int'(out_valid), 1 << d);
        chk_out("R2", d, s, pay);
        step();
        #1;
        chk("R3", "output drained", int'(out_valid), 0);
    endtask

    task automatic t_perm(bit compl);
        step();
        for (int i = 0; i < 8; i++) put(i, compl ? (i ^ 7) : i, 8'h40 + i);
        #1;
        chk("R7", "all eight accepted", int'(in_ready), 8'hFF);
        step();
        in_valid = '0;
        step();
        step();
        #1;
        chk("R7", "all eight delivered", int'(out_valid), 8'hFF);
        for (int p = 0; p < 8; p++) begin
            int s = compl ? (p ^ 7) : p;
            chk_out("R7", p, s, 8'h40 + s);
        end
        step();
    endtask

    task automatic t_contend();
        step();
        put(0, 0, 8'hC0);
        put(4, 1, 8'hC4);
        #1;
        chk("R5", "lower lane ready", int'(in_ready[0]), 1);
        chk("R5", "upper source stalled", int'(in_ready[4]), 0);
        step();
        in_valid[0] = 1'b0;
        #1;
        chk("R5", "loser accepted next cycle", int'(in_ready[4]), 1);
        step();
        in_valid = '0;
        step();
        #1;
        chk("R4", "winner output", int'(out_valid), 8'h01);
        chk_out("R5", 0, 0, 8'hC0);
        step();
        #1;
        chk("R4", "loser output one later", int'(out_valid), 8'h02);
        chk_out("R5", 1, 4, 8'hC4);
        step();
    endtask

    task automatic t_split();
        step();
        put(1, 2, 8'h21);
        put(5, 6, 8'h65);
        #1;
        chk("R6", "both inputs of element ready", int'(in_ready & 8'h22), 8'h22);
        step();
        in_valid = '0;
        step();
        step();
        #1;
        chk("R6", "both delivered together", int'(out_valid), 8'h44);
        chk_out("R4", 2, 1, 8'h21);
        chk_out("R4", 6, 5, 8'h65);
        step();
    endtask

    task automatic t_stream();
        step();
        for (int cyc = 0; cyc < 9; cyc++) begin
            if (cyc < 5) put(6, 3, 8'h60 + cyc);
            else in_valid = '0;
            #1;
            if (cyc < 5) chk("R8", "stream accepted", int'(in_ready[6]), 1);
            if (cyc >= 3 && cyc <= 7) begin
                chk("R8", "stream output valid", int'(out_valid), 8'h08);
                chk_out("R8", 3, 6, 8'h60 + cyc - 3);
            end
            if (cyc == 8) chk("R8", "stream drained", int'(out_valid), 0);
            step();
        end
    endtask

    task automatic t_block();
        step();
        out_ready[5] = 1'b0;
        for (int cyc = 0; cyc < 3; cyc++) begin
            put(2, 5, 8'h10 + cyc);
            #1;
            chk("R10", "absorbed while blocked", int'(in_ready[2]), 1);
            step();
        end
        put(2, 5, 8'h13);
        for (int cyc = 3; cyc < 6; cyc++) begin
            #1;
            chk("R10", "fourth packet stalled", int'(in_ready[2]), 0);
            chk("R9", "held valid", int'(out_valid[5]), 1);
            chk("R9", "held payload", o_dat(5), 8'h10);
            step();
        end
        out_ready[5] = 1'b1;
        #1;
        chk("R10", "ready returns on release", int'(in_ready[2]), 1);
        chk_out("R9", 5, 2, 8'h10);
        step();
        in_valid = '0;
        for (int n = 1; n < 4; n++) begin
            #1;
            chk("R9", "drain valid", int'(out_valid), 8'h20);
            chk("R9", "drain order", o_dat(5), 8'h10 + n);
            step();
        end
        #1;
        chk("R9", "drained", int'(out_valid), 0);
    endtask

    initial begin
        #(CLK_P * 100000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=done");
        summary();
        $finish;
    end

    initial begin
        t_reset();
        t_single(3, 6, 8'hA5);
        t_single(0, 7, 8'h17);
        t_single(5, 2, 8'h52);
        t_single(7, 0, 8'h70);
        t_perm(1'b0);
        t_perm(1'b1);
        t_contend();
        t_split();
        t_stream();
        t_block();
        summary();
        $finish;
    end

endmodule